// File: doc/BRIEF.md
# Seeded Power-On State Initializer

This block gives a machine a repeatable power-up state. When `start` is seen, it takes a 64-bit seed and runs a 64-bit counter-based bit mixer. The mixer produces 64-bit draws. The block writes the bytes of the first sixteen draws, one byte per clock, into a 128-byte RAM through a plain write port. It then takes three bytes of the seventeenth draw as preload values for a CPU's A, X and Y registers. Finally it pulses `done`. The RAM and the CPU are outside the block. The same seed always yields the same bytes.

Each draw goes through two 64×64 multiplies. Both multiplies use one shared iterative multiplier. `MUL_CHUNK` sets the multiplier width per cycle, so a draw takes more or fewer cycles. The byte order and the values do not depend on `MUL_CHUNK`.

A single state machine sequences the work. Its states and transitions are:
- `S_IDLE` moves to `S_STEP` on `start`. `S_STEP` advances the generator and moves to `S_MIX1`.
- `S_MIX1` hands the first product to the multiplier and moves to `S_WAIT1` once the multiplier is ready. `S_WAIT1` waits for the product and moves to `S_MIX2`.
- `S_MIX2` and `S_WAIT2` do the same for the second product. `S_WAIT2` then moves to `S_WRITE` while RAM draws remain, otherwise to `S_REGS`.
- `S_WRITE` emits eight bytes and returns to `S_STEP`.
- `S_REGS` latches the preloads and moves to `S_DONE`. `S_DONE` pulses `done` and returns to `S_IDLE`.

Top module: `seedfill_top`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `done` and `ram_we` are low, and `reg_a`, `reg_x` and `reg_y` are 0.
- R2: On `start`, the generator state is loaded from `seed`. Each draw first adds 0x9E3779B97F4A7C15 to the state (modulo 2^64), giving z. Then z = (z ^ (z>>30)) * 0xBF58476D1CE4E5B9, then z = (z ^ (z>>27)) * 0x94D049BB133111EB, both kept to 64 bits. The draw is z ^ (z>>31).
- R3: One run makes exactly 128 RAM writes, to addresses 0 to 127 in ascending order, each address once. Address 8*d+k receives bits [8k+7:8k] of draw d, with draws numbered from 0.
- R4: The eight writes of one draw occur on eight consecutive clock cycles.
- R5: From draw 16, byte 0 (bits 7:0) goes to `reg_a`, byte 1 to `reg_x` and byte 2 to `reg_y`. The three change together and then hold until a later run replaces them.
- R6: `busy` is high from the cycle after `start` is taken until `done`. `done` is high for exactly one cycle after the last write, with `busy` low and the preloads already valid.
- R7: Two runs with the same seed produce identical RAM bytes and preloads.
- R8: A `start` pulse, or a change of `seed`, while `busy` is high has no effect on the current run.
- R9: Raising `rst` in the middle of a run aborts it. No further writes occur, and the block stays idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (taken only when idle) |
| seed | input | 64 | Generator seed, sampled on start |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| reg_a | output | 8 | A register preload byte |
| reg_x | output | 8 | X register preload byte |
| reg_y | output | 8 | Y register preload byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each seed pattern targets a different part of the datapath:
- Seed 0 shows that the generator adds its increment before the first mix.
- Small seeds (1, 42) exercise a mostly-zero state where shift and XOR errors stand out.
- An all-ones seed forces a carry out of the 64-bit add.
- A mixed-bit seed catches wrong multiplier chunk alignment.

Every byte is compared against a model of the mixer, so any swapped byte lane, off-by-one address or wrong draw index appears as a mismatch. A second start with a different seed in mid-run must leave the first seed's image intact. A reset in mid-run must silence the write port.

// File: rtl/seedfill_pkg.sv
package seedfill_pkg;

    localparam logic [63:0] GEN_GAMMA = 64'h9E37_79B9_7F4A_7C15;
    localparam logic [63:0] MIX_K1    = 64'hBF58_476D_1CE4_E5B9;
    localparam logic [63:0] MIX_K2    = 64'h94D0_49BB_1331_11EB;
    localparam int          SH_PRE1   = 30;
    localparam int          SH_PRE2   = 27;
    localparam int          SH_POST   = 31;
    localparam int          DRAW_BYTES = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STEP,
        S_MIX1,
        S_WAIT1,
        S_MIX2,
        S_WAIT2,
        S_WRITE,
        S_REGS,
        S_DONE
    } fill_state_t;

endpackage

// File: rtl/seedfill_mul.sv
module seedfill_mul #(
    parameter int CHUNK = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        out_valid,
    output logic [63:0] product
);
    localparam int STEPS = 64 / CHUNK;

    generate
        if (STEPS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    product   <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        product <= op_a * op_b;
                    end
                end
            end
            assign in_ready = 1'b1;
        end else begin : g_iter
            localparam int CNT_W = $clog2(STEPS);
            logic             run_q;
            logic [CNT_W-1:0] cnt_q;
            logic [63:0]      acc_q;
            logic [63:0]      a_sh_q;
            logic [63:0]      b_sh_q;
            logic [63:0]      term;

            assign term     = a_sh_q * {{(64-CHUNK){1'b0}}, b_sh_q[CHUNK-1:0]};
            assign in_ready = !run_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q     <= 1'b0;
                    cnt_q     <= '0;
                    acc_q     <= '0;
                    a_sh_q    <= '0;
                    b_sh_q    <= '0;
                    out_valid <= 1'b0;
                    product   <= '0;
                end else begin
                    out_valid <= 1'b0;
                    if (!run_q) begin
                        if (in_valid) begin
                            run_q  <= 1'b1;
                            cnt_q  <= '0;
                            acc_q  <= '0;
                            a_sh_q <= op_a;
                            b_sh_q <= op_b;
                        end
                    end else begin
                        acc_q  <= acc_q + term;
                        a_sh_q <= a_sh_q << CHUNK;
                        b_sh_q <= b_sh_q >> CHUNK;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(STEPS - 1)) begin
                            run_q     <= 1'b0;
                            out_valid <= 1'b1;
                            product   <= acc_q + term;
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/seedfill_ctrl.sv
module seedfill_ctrl
    import seedfill_pkg::*;
#(
    parameter int RAM_BYTES = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [63:0]                  seed,
    output logic                         mul_in_valid,
    input  logic                         mul_in_ready,
    output logic [63:0]                  mul_a,
    output logic [63:0]                  mul_b,
    input  logic                         mul_out_valid,
    input  logic [63:0]                  mul_p,
    output logic                         ram_we,
    output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
    output logic [7:0]                   ram_wdata,
    output logic [7:0]                   reg_a,
    output logic [7:0]                   reg_x,
    output logic [7:0]                   reg_y,
    output logic                         busy,
    output logic                         done
);
    localparam int ADDR_W    = $clog2(RAM_BYTES);
    localparam int BYTE_W    = $clog2(DRAW_BYTES);
    localparam int RAM_DRAWS = RAM_BYTES / DRAW_BYTES;
    localparam int DCNT_W    = $clog2(RAM_DRAWS + 1);
    localparam int DIDX_W    = ADDR_W - BYTE_W;

    fill_state_t       state_q, state_d;
    logic [63:0]       gen_q;
    logic [63:0]       z_q;
    logic [63:0]       draw_q;
    logic [DCNT_W-1:0] dcnt_q;
    logic [BYTE_W-1:0] bidx_q;
    logic              last_byte;
    logic              fill_over;

    assign last_byte = (bidx_q == BYTE_W'(DRAW_BYTES - 1));
    assign fill_over = (dcnt_q == DCNT_W'(RAM_DRAWS));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_STEP;
            S_STEP:  state_d = S_MIX1;
            S_MIX1:  if (mul_in_ready) state_d = S_WAIT1;
            S_WAIT1: if (mul_out_valid) state_d = S_MIX2;
            S_MIX2:  if (mul_in_ready) state_d = S_WAIT2;
            S_WAIT2: if (mul_out_valid) state_d = fill_over ? S_REGS : S_WRITE;
            S_WRITE: if (last_byte) state_d = S_STEP;
            S_REGS:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q  <= '0;
            z_q    <= '0;
            draw_q <= '0;
            dcnt_q <= '0;
            bidx_q <= '0;
            reg_a  <= '0;
            reg_x  <= '0;
            reg_y  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        gen_q  <= seed;
                        dcnt_q <= '0;
                    end
                end
                S_STEP: gen_q <= gen_q + GEN_GAMMA;
                S_WAIT1: if (mul_out_valid) z_q <= mul_p;
                S_WAIT2: begin
                    if (mul_out_valid) begin
                        draw_q <= mul_p ^ (mul_p >> SH_POST);
                        bidx_q <= '0;
                    end
                end
                S_WRITE: begin
                    bidx_q <= bidx_q + 1'b1;
                    if (last_byte) dcnt_q <= dcnt_q + 1'b1;
                end
                S_REGS: begin
                    reg_a <= draw_q[7:0];
                    reg_x <= draw_q[15:8];
                    reg_y <= draw_q[23:16];
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mul_in_valid = 1'b0;
        mul_a        = gen_q ^ (gen_q >> SH_PRE1);
        mul_b        = MIX_K1;
        ram_we       = 1'b0;
        busy         = 1'b1;
        done         = 1'b0;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_MIX1:  mul_in_valid = 1'b1;
            S_MIX2: begin
                mul_in_valid = 1'b1;
                mul_a        = z_q ^ (z_q >> SH_PRE2);
                mul_b        = MIX_K2;
            end
            S_WRITE: ram_we = 1'b1;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign ram_addr  = {dcnt_q[DIDX_W-1:0], bidx_q};
    assign ram_wdata = draw_q[{bidx_q, 3'b000} +: 8];

endmodule

// File: rtl/seedfill_top.sv
module seedfill_top #(
    parameter int RAM_BYTES = 128,
    parameter int MUL_CHUNK = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [63:0]                  seed,
    output logic                         ram_we,
    output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
    output logic [7:0]                   ram_wdata,
    output logic [7:0]                   reg_a,
    output logic [7:0]                   reg_x,
    output logic [7:0]                   reg_y,
    output logic                         busy,
    output logic                         done
);
    logic        m_in_valid;
    logic        m_in_ready;
    logic [63:0] m_a;
    logic [63:0] m_b;
    logic        m_out_valid;
    logic [63:0] m_p;

    seedfill_ctrl #(.RAM_BYTES(RAM_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .seed(seed),
        .mul_in_valid(m_in_valid), .mul_in_ready(m_in_ready),
        .mul_a(m_a), .mul_b(m_b),
        .mul_out_valid(m_out_valid), .mul_p(m_p),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .busy(busy), .done(done)
    );

    seedfill_mul #(.CHUNK(MUL_CHUNK)) u_mul (
        .clk(clk), .rst(rst),
        .in_valid(m_in_valid), .in_ready(m_in_ready),
        .op_a(m_a), .op_b(m_b),
        .out_valid(m_out_valid), .product(m_p)
    );

endmodule

// File: rtl/seedfill_chk.sv
module seedfill_chk #(
    parameter int RAM_BYTES = 128
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         ram_we,
    input logic [$clog2(RAM_BYTES)-1:0] ram_addr,
    input logic [7:0]                   reg_a,
    input logic [7:0]                   reg_x,
    input logic [7:0]                   reg_y,
    input logic                         busy,
    input logic                         done
);
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_addr_ascend_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

    p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable({reg_a, reg_x, reg_y}));

endmodule

bind seedfill_top seedfill_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
    .clk(clk), .rst(rst), .ram_we(ram_we), .ram_addr(ram_addr),
    .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .busy(busy), .done(done)
);

// File: tb/test_seedfill_top.sv
module test_seedfill_top;
    localparam int NB = 128;
    localparam logic [63:0] SEEDS [5] = '{64'h0, 64'h1, 64'd42,
                                          64'h0123_4567_DEAD_BEEF,
                                          64'hFFFF_FFFF_FFFF_FFFF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] seed = '0;
    logic        ram_we;
    logic [6:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  reg_a, reg_x, reg_y;
    logic        busy, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0] cap_ram [NB];
    bit         cap_seen [NB];
    int         cap_cyc [NB];
    int         wr_cnt, dups, busy_gaps;
    bit         done_seen;
    logic [7:0] cap_a, cap_x, cap_y;
    logic [7:0] keep_ram [NB];
    logic [7:0] keep_a, keep_x, keep_y;

    always #10 clk = ~clk;

    seedfill_top i_seedfill_top (
        .clk(clk), .rst(rst), .start(start), .seed(seed),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .busy(busy), .done(done)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    function automatic logic [63:0] draw_of(input logic [63:0] sd, input int k);
        logic [63:0] z;
        z = sd + 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
        z = (z ^ (z >> 30)) * 64'hBF58_476D_1CE4_E5B9;
        z = (z ^ (z >> 27)) * 64'h94D0_49BB_1331_11EB;
        return z ^ (z >> 31);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] sd, input bit inject, input logic [63:0] sd2);
        int t;
        for (int i = 0; i < NB; i++) begin
            cap_seen[i] = 1'b0;
            cap_ram[i]  = '0;
            cap_cyc[i]  = 0;
        end
        wr_cnt = 0; dups = 0; busy_gaps = 0; done_seen = 1'b0;
        @(negedge clk);
        seed  = sd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (t < 4000 && !done_seen) begin
            if (done) begin
                done_seen = 1'b1;
                chk(!busy, "R6 busy in done cycle", 64'(busy), 64'h0);
                cap_a = reg_a; cap_x = reg_x; cap_y = reg_y;
            end else if (!busy) begin
                busy_gaps++;
            end
            if (ram_we) begin
                if (cap_seen[ram_addr]) dups++;
                cap_seen[ram_addr] = 1'b1;
                cap_ram[ram_addr]  = ram_wdata;
                cap_cyc[ram_addr]  = t;
                wr_cnt++;
            end
            if (inject && t == 60) begin
                start = 1'b1;
                seed  = sd2;
            end else begin
                start = 1'b0;
            end
            if (!done_seen) begin
                @(negedge clk);
                t++;
            end
        end
        chk(done_seen, "R6 done reached", 64'(done_seen), 64'h1);
        chk(busy_gaps == 0, "R6 busy through run", 64'(busy_gaps), 64'h0);
        @(negedge clk);
        chk(!done, "R6 done one cycle", 64'(done), 64'h0);
        chk(!busy, "R6 idle after done", 64'(busy), 64'h0);
    endtask

    task automatic check_run(input logic [63:0] sd);
        logic [63:0] d;
        chk(wr_cnt == NB, "R3 write count", 64'(wr_cnt), 64'(NB));
        chk(dups == 0, "R3 duplicate address", 64'(dups), 64'h0);
        for (int i = 0; i < NB; i++) begin
            d = draw_of(sd, i / 8);
            chk(cap_seen[i] && cap_ram[i] == d[8*(i%8) +: 8], "R2 R3 RAM byte",
                64'(cap_ram[i]), 64'(d[8*(i%8) +: 8]));
        end
        for (int g = 0; g < NB / 8; g++) begin
            bit ok = 1'b1;
            for (int k = 1; k < 8; k++)
                if (cap_cyc[g*8+k] != cap_cyc[g*8] + k) ok = 1'b0;
            chk(ok, "R4 consecutive writes", 64'(cap_cyc[g*8+7] - cap_cyc[g*8]), 64'h7);
        end
        d = draw_of(sd, NB / 8);
        chk(cap_a == d[7:0],   "R5 reg_a", 64'(cap_a), 64'(d[7:0]));
        chk(cap_x == d[15:8],  "R5 reg_x", 64'(cap_x), 64'(d[15:8]));
        chk(cap_y == d[23:16], "R5 reg_y", 64'(cap_y), 64'(d[23:16]));
        chk(reg_a == cap_a && reg_x == cap_x && reg_y == cap_y, "R5 preloads held",
            64'({reg_a, reg_x, reg_y}), 64'({cap_a, cap_x, cap_y}));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ram_we, "R1 controls in reset",
            64'({busy, done, ram_we}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !ram_we, "R1 controls after reset",
            64'({busy, done, ram_we}), 64'h0);
        chk({reg_a, reg_x, reg_y} == 24'h0, "R1 preloads after reset",
            64'({reg_a, reg_x, reg_y}), 64'h0);

        // seed table walk
        foreach (SEEDS[s]) begin
            run(SEEDS[s], 1'b0, '0);
            check_run(SEEDS[s]);
        end

        // R7: determinism
        run(64'd42, 1'b0, '0);
        for (int i = 0; i < NB; i++) keep_ram[i] = cap_ram[i];
        keep_a = cap_a; keep_x = cap_x; keep_y = cap_y;
        run(64'h5555_AAAA_0000_FFFF, 1'b0, '0);
        run(64'd42, 1'b0, '0);
        begin
            int diff = 0;
            for (int i = 0; i < NB; i++) if (keep_ram[i] != cap_ram[i]) diff++;
            chk(diff == 0, "R7 RAM repeat", 64'(diff), 64'h0);
        end
        chk({keep_a, keep_x, keep_y} == {cap_a, cap_x, cap_y}, "R7 preload repeat",
            64'({cap_a, cap_x, cap_y}), 64'({keep_a, keep_x, keep_y}));

        // R8: start and seed change during a run are ignored
        run(64'h0123_4567_DEAD_BEEF, 1'b1, 64'h7);
        check_run(64'h0123_4567_DEAD_BEEF);

        // R9: reset in mid-run aborts
        @(negedge clk);
        seed  = 64'h3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        begin
            int act = 0;
            for (int t = 0; t < 30; t++) begin
                @(negedge clk);
                if (ram_we || busy || done) act++;
            end
            chk(act == 0, "R9 silent after abort", 64'(act), 64'h0);
        end
        chk({reg_a, reg_x, reg_y} == 24'h0, "R9 R1 preloads cleared",
            64'({reg_a, reg_x, reg_y}), 64'h0);
        run(64'h3, 1'b0, '0);
        check_run(64'h3);

        summary();
    end

endmodule